// File: doc/BRIEF.md
# Configurable Edge-Triggered Interrupt Controller

This block watches a set of asynchronous interrupt lines and turns selected transitions on them into pending flags and one-clock interrupt pulses. Each line is first brought into the controller's clock domain by a two-flop synchronizer. The synchronized value is then compared with a register that holds the line's last observed level. A difference is an edge. The stored level follows the line at all times, including while the line is masked, so unmasking a line that changed while masked produces no edge.

The lines are grouped into banks of 32. Each bank has its own mask, event-mask, rising-select, falling-select, software-trigger and pending registers, and software programs them through a word-addressed write/read port. Each register is 32 bits wide and there is one bit per line. Pending flags are cleared by writing ones. Software can also raise an interrupt on a line by writing to the trigger register. The event-mask register is storage only and is kept for a downstream event router.

Top module: `edge_irq_ctrl`

## Requirements
- R1: The controller keeps a stored level for every line. A line whose synchronized level stays equal to its stored level sets nothing and pulses nothing, however long it is held.
- R2: The stored level follows the line even while the line is masked. Setting the mask bit of a line that changed while masked produces no pulse and no pending flag.
- R3: A line whose mask bit is 0 never sets its pending flag and never pulses its interrupt output, whether the cause is an edge or a software trigger.
- R4: An unmasked line sets its pending flag when its new level is 1 and its rising-select bit is 1, or when its new level is 0 and its falling-select bit is 1. With both select bits set, both edges trigger.
- R5: An edge that does not match the line's select bits, or an edge on a line with neither select bit set, changes no pending flag and produces no pulse.
- R6: On the clock edge where a line's pending flag is set, `irq_pulse` for that line goes high for exactly one cycle.
- R7: Reset (synchronous, `rst_n` low) clears all mask, event-mask, rising, falling, software-trigger, pending and stored-level registers of every bank, and clears `irq_pulse`.
- R8: The register address is laid out as follows. `reg_addr[3]` selects the bank and `reg_addr[2:0]` selects the register: 0 mask, 1 event-mask, 2 rising-select, 3 falling-select, 4 software-trigger, 5 pending. Offsets 6 and 7 read zero. Line i sits at bit i mod 32 of bank i/32. `reg_rdata` shows the addressed register combinationally.
- R9: Writing to the pending register clears each flag whose data bit is 1. A 0 data bit leaves the flag unchanged. Nothing else clears a flag.
- R10: If a clear write and a new set hit the same pending bit on the same clock edge, the flag ends up set.
- R11: Writing 1 to a software-trigger bit of an unmasked line sets its pending flag and pulses its output on that clock edge, and the trigger bit reads 1 until the pending flag is cleared. On a masked line the write has no effect.
- R12: A level change on `line_in` driven just after a clock edge first shows in `irq_pulse` and in the pending flag after the third following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 64 | Asynchronous interrupt lines, line i at bit i |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word address: bank and register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Addressed register value |
| irq_pulse | output | 64 | One-cycle interrupt pulse per line |

## Verification
Two things can fall on the same pending bit on the same clock edge: a software clear and a new set, either from a hardware edge or from a software trigger. The directed part raises a line and times a write-one-to-clear of that line's flag so that it lands exactly on the edge where the synchronized edge is detected. The flag must then read 1 and the pulse must appear. The random part toggles lines while it writes pending, trigger and mask registers at random. Each cycle it compares the pulses, and at intervals the pending registers, against a bench model in which a set always beats a clear.

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
  parameter int BANK_W = 32,
  parameter int BANKS  = 2,
  localparam int NL = BANK_W * BANKS,
  localparam int BW = $clog2(BANKS),
  localparam int AW = BW + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NL-1:0]     line_in,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [BANK_W-1:0] reg_wdata,
  output logic [BANK_W-1:0] reg_rdata,
  output logic [NL-1:0]     irq_pulse
);
  localparam logic [2:0] OFF_MASK = 3'd0;
  localparam logic [2:0] OFF_EVM  = 3'd1;
  localparam logic [2:0] OFF_RISE = 3'd2;
  localparam logic [2:0] OFF_FALL = 3'd3;
  localparam logic [2:0] OFF_SWT  = 3'd4;
  localparam logic [2:0] OFF_PEND = 3'd5;

  logic [NL-1:0] sync1_q, sync2_q, lvl_q;
  logic [NL-1:0] mask_q, evm_q, rise_q, fall_q, swt_q, pend_q;
  logic [NL-1:0] hw_hit, sw_hit, clr_bits, set_bits;

  wire [BW-1:0] sel_bank = reg_addr[AW-1:3];
  wire [2:0]    sel_off  = reg_addr[2:0];

  assign hw_hit   = (sync2_q ^ lvl_q) & mask_q & ((sync2_q & rise_q) | (~sync2_q & fall_q));
  assign set_bits = hw_hit | sw_hit;

  always_comb begin
    clr_bits = '0;
    sw_hit   = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (reg_we && sel_bank == BW'(b)) begin
        if (sel_off == OFF_PEND) clr_bits[b*BANK_W +: BANK_W] = reg_wdata;
        if (sel_off == OFF_SWT)  sw_hit[b*BANK_W +: BANK_W]   = reg_wdata;
      end
    end
    sw_hit = sw_hit & mask_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q   <= '0;
      sync2_q   <= '0;
      lvl_q     <= '0;
      mask_q    <= '0;
      evm_q     <= '0;
      rise_q    <= '0;
      fall_q    <= '0;
      swt_q     <= '0;
      pend_q    <= '0;
      irq_pulse <= '0;
    end else begin
      sync1_q   <= line_in;
      sync2_q   <= sync1_q;
      lvl_q     <= sync2_q;
      pend_q    <= (pend_q & ~clr_bits) | set_bits;
      swt_q     <= (swt_q & ~clr_bits) | sw_hit;
      irq_pulse <= set_bits;
      for (int b = 0; b < BANKS; b++) begin
        if (reg_we && sel_bank == BW'(b)) begin
          case (sel_off)
            OFF_MASK: mask_q[b*BANK_W +: BANK_W] <= reg_wdata;
            OFF_EVM:  evm_q[b*BANK_W +: BANK_W]  <= reg_wdata;
            OFF_RISE: rise_q[b*BANK_W +: BANK_W] <= reg_wdata;
            OFF_FALL: fall_q[b*BANK_W +: BANK_W] <= reg_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (sel_bank == BW'(b)) begin
        case (sel_off)
          OFF_MASK: reg_rdata = mask_q[b*BANK_W +: BANK_W];
          OFF_EVM:  reg_rdata = evm_q[b*BANK_W +: BANK_W];
          OFF_RISE: reg_rdata = rise_q[b*BANK_W +: BANK_W];
          OFF_FALL: reg_rdata = fall_q[b*BANK_W +: BANK_W];
          OFF_SWT:  reg_rdata = swt_q[b*BANK_W +: BANK_W];
          OFF_PEND: reg_rdata = pend_q[b*BANK_W +: BANK_W];
          default:  reg_rdata = '0;
        endcase
      end
    end
  end
endmodule

module edge_irq_ctrl_chk #(
  parameter int BANK_W = 32,
  parameter int BANKS  = 2,
  localparam int NL = BANK_W * BANKS,
  localparam int BW = $clog2(BANKS),
  localparam int AW = BW + 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [AW-1:0]     reg_addr,
  input logic [BANK_W-1:0] reg_wdata,
  input logic [NL-1:0]     irq_pulse,
  input logic [NL-1:0]     pend,
  input logic [NL-1:0]     mask,
  input logic [NL-1:0]     lvl
);
  logic [NL-1:0] wr_clr, wr_sw;

  always_comb begin
    wr_clr = '0;
    wr_sw  = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (reg_we && reg_addr[AW-1:3] == BW'(b)) begin
        if (reg_addr[2:0] == 3'd5) wr_clr[b*BANK_W +: BANK_W] = reg_wdata;
        if (reg_addr[2:0] == 3'd4) wr_sw[b*BANK_W +: BANK_W]  = reg_wdata;
      end
    end
  end

  p_pulse_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse & ~pend) == '0);

  p_new_pending_pulses_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~irq_pulse) == '0));

  p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_pulse & ~$past(mask)) == '0));

  p_clear_by_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~pend & $past(pend) & ~$past(wr_clr)) == '0));

  p_pulse_has_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_pulse & ~$past(wr_sw) & ~(lvl ^ $past(lvl))) == '0));
endmodule

bind edge_irq_ctrl edge_irq_ctrl_chk #(.BANK_W(BANK_W), .BANKS(BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .irq_pulse(irq_pulse), .pend(pend_q), .mask(mask_q), .lvl(lvl_q)
);

// File: tb/test_edge_irq_ctrl.sv
module test_edge_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] line_in = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] irq_pulse;

  edge_irq_ctrl i_edge_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pulse(irq_pulse)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [63:0] lines = '0;
  logic [63:0] seen = '0;
  bit auto_chk = 0;

  logic [63:0] m_s1, m_s2, m_lvl, m_mask, m_ev, m_rise, m_fall, m_swt, m_pend, m_irq;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void model_clear();
    m_s1 = '0; m_s2 = '0; m_lvl = '0; m_mask = '0; m_ev = '0;
    m_rise = '0; m_fall = '0; m_swt = '0; m_pend = '0; m_irq = '0;
  endfunction

  function automatic void model_step(input logic [63:0] in, input logic we,
                                     input logic [3:0] a, input logic [31:0] d);
    logic [63:0] hw, sw, clr, wv, bm, set;
    hw  = (m_s2 ^ m_lvl) & m_mask & ((m_s2 & m_rise) | (~m_s2 & m_fall));
    wv  = we ? ({32'd0, d} << (a[3] * 32)) : 64'd0;
    bm  = we ? (64'h0000_0000_FFFF_FFFF << (a[3] * 32)) : 64'd0;
    sw  = (a[2:0] == 3'd4) ? (wv & m_mask) : 64'd0;
    clr = (a[2:0] == 3'd5) ? wv : 64'd0;
    set = hw | sw;
    m_pend = (m_pend & ~clr) | set;
    m_swt  = (m_swt & ~clr) | sw;
    m_irq  = set;
    m_lvl  = m_s2;
    m_s2   = m_s1;
    m_s1   = in;
    case (a[2:0])
      3'd0: m_mask = (m_mask & ~bm) | wv;
      3'd1: m_ev   = (m_ev & ~bm) | wv;
      3'd2: m_rise = (m_rise & ~bm) | wv;
      3'd3: m_fall = (m_fall & ~bm) | wv;
      default: ;
    endcase
  endfunction

  function automatic logic [31:0] model_read(input logic [3:0] a);
    logic [63:0] r;
    case (a[2:0])
      3'd0: r = m_mask;
      3'd1: r = m_ev;
      3'd2: r = m_rise;
      3'd3: r = m_fall;
      3'd4: r = m_swt;
      3'd5: r = m_pend;
      default: r = '0;
    endcase
    return a[3] ? r[63:32] : r[31:0];
  endfunction

  task automatic tick(input logic we, input logic [3:0] a, input logic [31:0] d);
    line_in = lines; reg_we = we; reg_addr = a; reg_wdata = d;
    if (rst_n) model_step(lines, we, a, d); else model_clear();
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
    seen |= irq_pulse;
    if (auto_chk) chk("R4 R6 pulse vector vs model", irq_pulse, m_irq);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 4'd0, 32'd0);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_we = 1'b0; reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_1234));
    model_clear();
    @(negedge clk);
    idle(3);
    rst_n = 1'b1;

    // R7 R8: every register reads zero after reset, unused offsets too
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      chk($sformatf("R7 reset value addr %0d", a), {32'd0, v}, 64'd0);
    end
    chk("R7 irq after reset", irq_pulse, 64'd0);

    // configure bank 0: mask 3,5,7,9,11; rising 3,7,9; falling 5,7
    tick(1'b1, 4'd0, 32'h0000_0AA8);
    tick(1'b1, 4'd2, 32'h0000_0288);
    tick(1'b1, 4'd3, 32'h0000_00A0);

    // R12 R6: rising edge on line 3 appears after third edge, for one cycle
    lines[3] = 1'b1; seen = '0;
    idle(2);
    chk("R12 no pulse before third edge", seen, 64'd0);
    idle(1);
    chk("R12 R4 pulse on rising edge line 3", irq_pulse, 64'h8);
    rd(4'd5, v);
    chk("R6 pending set with pulse", {32'd0, v}, 64'h8);
    idle(1);
    chk("R6 pulse lasts one cycle", irq_pulse, 64'd0);
    seen = '0; idle(6);
    chk("R1 steady high level gives nothing", seen, 64'd0);

    // R5: falling edge on rising-only line, and edge on line with no select
    lines[3] = 1'b0; lines[11] = 1'b1; seen = '0; idle(6);
    chk("R5 unselected edges give no pulse", seen, 64'd0);
    rd(4'd5, v);
    chk("R5 pending unchanged", {32'd0, v}, 64'h8);

    // R9: write of zero keeps flag, write of one clears it
    tick(1'b1, 4'd5, 32'h0);
    rd(4'd5, v);
    chk("R9 zero write leaves flag", {32'd0, v}, 64'h8);
    tick(1'b1, 4'd5, 32'h8);
    rd(4'd5, v);
    chk("R9 one write clears flag", {32'd0, v}, 64'h0);

    // R4: falling-only line 5 and both-edges line 7
    lines[5] = 1'b1; seen = '0; idle(5);
    chk("R4 rising ignored on falling-only line", seen, 64'd0);
    lines[5] = 1'b0; seen = '0; idle(5);
    chk("R4 falling edge on line 5", seen, 64'h20);
    lines[7] = 1'b1; seen = '0; idle(5);
    chk("R4 both-select rising on line 7", seen, 64'h80);
    lines[7] = 1'b0; seen = '0; idle(5);
    chk("R4 both-select falling on line 7", seen, 64'h80);
    tick(1'b1, 4'd5, 32'hFFFF_FFFF);

    // R3 R2 R8: bank 1 line 40 (bit 8) masked, then unmasked
    tick(1'b1, 4'd10, 32'h0000_0100);
    lines[40] = 1'b1; seen = '0; idle(6);
    chk("R3 masked line does not pulse", seen, 64'd0);
    rd(4'd13, v);
    chk("R3 masked line pending stays clear", {32'd0, v}, 64'd0);
    tick(1'b1, 4'd8, 32'h0000_0100);
    seen = '0; idle(6);
    chk("R2 unmask after change gives no pulse", seen, 64'd0);
    lines[40] = 1'b0; idle(5);
    lines[40] = 1'b1; seen = '0; idle(5);
    chk("R8 bank 1 line 40 pulses on bit 40", seen, 64'h0000_0100_0000_0000);
    rd(4'd13, v);
    chk("R8 bank 1 pending bit 8", {32'd0, v}, 64'h100);

    // R10: clear write lands on the same edge as a new set of line 9
    lines[9] = 1'b1; idle(4);
    lines[9] = 1'b0; idle(4);
    rd(4'd5, v);
    chk("R10 setup pending bit 9", {32'd0, v}, 64'h200);
    lines[9] = 1'b1;
    idle(2);
    tick(1'b1, 4'd5, 32'h200);
    chk("R10 pulse despite clear", irq_pulse, 64'h200);
    rd(4'd5, v);
    chk("R10 set wins over clear", {32'd0, v}, 64'h200);

    // R11: software trigger on unmasked line 3, then on masked line 20
    tick(1'b1, 4'd4, 32'h8);
    chk("R11 software trigger pulses", irq_pulse, 64'h8);
    rd(4'd4, v);
    chk("R11 trigger bit reads one", {32'd0, v}, 64'h8);
    tick(1'b1, 4'd5, 32'h8);
    rd(4'd4, v);
    chk("R11 trigger bit clears with pending", {32'd0, v}, 64'h0);
    tick(1'b1, 4'd4, 32'h0010_0000);
    chk("R11 masked trigger no pulse", irq_pulse, 64'd0);
    rd(4'd5, v);
    chk("R11 masked trigger leaves pending", {32'd0, v}, 64'h200);
    rd(4'd4, v);
    chk("R11 masked trigger bit stays zero", {32'd0, v}, 64'h0);

    // R8: event-mask storage and unused offset
    tick(1'b1, 4'd9, 32'hA5A5_0001);
    rd(4'd9, v);
    chk("R8 event-mask bank 1 readback", {32'd0, v}, 64'hA5A5_0001);
    rd(4'd1, v);
    chk("R8 event-mask bank 0 untouched", {32'd0, v}, 64'h0);
    rd(4'd14, v);
    chk("R8 unused offset reads zero", {32'd0, v}, 64'h0);

    // random phase against the bench model
    auto_chk = 1;
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] flip;
      flip = {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom};
      lines ^= flip;
      if (($urandom % 4) == 0) begin
        logic [3:0] a;
        a = 4'($urandom % 16);
        tick(1'b1, a, (a[2:0] == 3'd4) ? ($urandom & $urandom) : $urandom);
      end else begin
        tick(1'b0, 4'd0, 32'd0);
      end
      if ((i % 16) == 15) begin
        rd(4'd5, v);
        chk("R9 R10 pending bank 0 vs model", {32'd0, v}, {32'd0, model_read(4'd5)});
        rd(4'd13, v);
        chk("R9 R10 pending bank 1 vs model", {32'd0, v}, {32'd0, model_read(4'd13)});
      end
    end
    auto_chk = 0;
    finish_run();
  end
endmodule